// File: doc/BRIEF.md
# Sign-Extended Serial DAC Transmitter

This block turns signed 16-bit stereo sample pairs into a three-wire serial stream for a digital-to-analogue converter. The three wires are a bit clock, a word select and a data line. Every channel slot lasts 24 bit clocks. The slot is right-justified: the sample's sign bit is sent eight extra times, and then come the 16 sample bits, most significant first. Each frame carries the left slot first and the right slot second. Word select is high during the left slot and low during the right slot.

The bit clock comes from the system clock through an even divider. The data line and word select change only when the bit clock falls, so the converter can sample them on the rising edge. At each frame boundary the block raises `pairReady` for a single system clock. If `pairValid` is high in that cycle, the block takes in the pair on the sample inputs. If `pairValid` is low, the block sends the pair it already holds again. A sample source can therefore run from this strobe and never stall the stream.

Top module: `signext_dac_tx`

## Requirements
- R1: Each left slot sends eight copies of bit 15 of the left sample, then left bits 15 down to 0, one bit per bit clock.
- R2: Each right slot follows the left slot directly and has the same layout, built from the right sample of the same pair.
- R3: Word select is 1 for all 24 bits of the left slot and 0 for all 24 bits of the right slot. It changes together with the first sign-copy bit of each slot.
- R4: The data line and word select change only on a system clock edge where the bit clock goes from 1 to 0. Both are therefore stable at each rising edge of the bit clock.
- R5: The bit clock has a period of CLK_DIV system clocks and stays high for CLK_DIV/2 of them. It is low while reset is held and just after reset.
- R6: `pairReady` is high for exactly one system clock at the start of each frame. A pair with `pairValid` high in that cycle is the pair sent in that frame.
- R7: If `pairValid` is low when `pairReady` is high, the frame repeats the previously held pair. Sample input values at any other time have no effect.
- R8: Reset drives the bit clock, word select, data and `pairReady` to 0 and clears the held pair to zero. The first bit clock falling edge after reset starts a left slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pairValid | input | 1 | A new stereo pair is offered |
| leftIn | input | 16 | Left sample, two's complement |
| rightIn | input | 16 | Right sample, two's complement |
| pairReady | output | 1 | One-cycle strobe at frame start; the pair is taken if valid |
| bitClk | output | 1 | Serial bit clock |
| wordSel | output | 1 | 1 = left slot, 0 = right slot |
| serData | output | 1 | Serial data, MSB first |

## Verification
The hardest case to bring about is the repeat of a held pair after the inputs have moved on. The stimulus must land `pairValid` low exactly in the single cycle where `pairReady` is high, with sample inputs that are different from the held pair. The bench waits for the strobe and then drives new values on the sample inputs with `pairValid` held low. It then confirms that the next serial frame still carries the earlier pair.

Sign extension is tested with patterns chosen for it: both extremes of the 16-bit range, -1, zero, and values whose top bit differs between the left and right channels.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Strobes from control to datapath, all aligned to a bit clock fall
  typedef struct packed {
    logic frameStart;   // first bit of the left slot
    logic rightStart;   // first bit of the right slot
    logic shiftBit;     // advance to the next bit within a slot
  } slotStrobe_t;

endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int SLOT_W  = 24
) (
  input  logic        clk,
  input  logic        rstN,
  output logic        bitClk,
  output slotStrobe_t strb
);

  localparam int HALF       = CLK_DIV / 2;
  localparam int DIV_W      = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] RIGHT_IDX = IDX_W'(SLOT_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             bitClkQ;
  logic             fallTick;
  logic             riseTick;

  assign fallTick = (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseTick = (divCnt == DIV_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitIdx  <= LAST_IDX;
      bitClkQ <= 1'b0;
    end else begin
      divCnt <= fallTick ? '0 : divCnt + DIV_W'(1);
      if (fallTick) begin
        bitClkQ <= 1'b0;
        bitIdx  <= (bitIdx == LAST_IDX) ? '0 : bitIdx + IDX_W'(1);
      end else if (riseTick) begin
        bitClkQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.frameStart = fallTick && (bitIdx == LAST_IDX);
    strb.rightStart = fallTick && (bitIdx == RIGHT_IDX);
    strb.shiftBit   = fallTick && !strb.frameStart && !strb.rightStart;
  end

  assign bitClk = bitClkQ;

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.frameStart, strb.rightStart, strb.shiftBit}));

  // R5
  fall_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bitClkQ) |-> (divCnt == '0));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> !strb.frameStart);

endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PAD_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  slotStrobe_t         strb,
  input  logic                bitClk,
  input  logic                pairValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                wordSel,
  output logic                serData
);

  localparam int SLOT_W = SAMPLE_W + PAD_W;
  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] chanIn   [NUM_CH];
  logic [SAMPLE_W-1:0] chanHold [NUM_CH];
  logic [SAMPLE_W-1:0] leftPick;
  logic [SLOT_W-1:0]   slotReg;
  logic                wordSelQ;

  assign chanIn[0] = leftIn;
  assign chanIn[1] = rightIn;

  function automatic logic [SLOT_W-1:0] padSigned(input logic [SAMPLE_W-1:0] s);
    return {{PAD_W{s[SAMPLE_W-1]}}, s};
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rstN)
        chanHold[ch] <= '0;
      else if (strb.frameStart && pairValid)
        chanHold[ch] <= chanIn[ch];
    end
  end

  assign leftPick = pairValid ? leftIn : chanHold[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotReg  <= '0;
      wordSelQ <= 1'b0;
    end else if (strb.frameStart) begin
      slotReg  <= padSigned(leftPick);
      wordSelQ <= 1'b1;
    end else if (strb.rightStart) begin
      slotReg  <= padSigned(chanHold[1]);
      wordSelQ <= 1'b0;
    end else if (strb.shiftBit) begin
      slotReg  <= {slotReg[SLOT_W-2:0], 1'b0};
    end
  end

  assign serData = slotReg[SLOT_W-1];
  assign wordSel = wordSelQ;

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> $fell(bitClk));

  // R3
  ws_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordSel) |-> $fell(bitClk));

  // R1
  left_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart && pairValid) |=> (wordSel && serData == $past(leftIn[SAMPLE_W-1])));

  // R7
  repeat_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameStart && !pairValid) |=> (serData == $past(chanHold[0][SAMPLE_W-1])));

endmodule

// File: rtl/signext_dac_tx.sv
module signext_dac_tx
  import sdac_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PAD_W    = 8,
  parameter int CLK_DIV  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pairValid,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                pairReady,
  output logic                bitClk,
  output logic                wordSel,
  output logic                serData
);

  localparam int SLOT_W = SAMPLE_W + PAD_W;

  slotStrobe_t strb;

  sdac_ctrl #(
    .CLK_DIV (CLK_DIV),
    .SLOT_W  (SLOT_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .bitClk (bitClk),
    .strb   (strb)
  );

  sdac_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .PAD_W    (PAD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitClk    (bitClk),
    .pairValid (pairValid),
    .leftIn    (leftIn),
    .rightIn   (rightIn),
    .wordSel   (wordSel),
    .serData   (serData)
  );

  assign pairReady = strb.frameStart;

  // R6
  ready_ws_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairReady |=> wordSel);

endmodule

// File: tb/signext_dac_tx_test.sv
module signext_dac_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NVEC       = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h1234, 16'hABCD},
    {16'h8000, 16'h7FFF},
    {16'hFFFF, 16'h0001},
    {16'h0000, 16'h8001},
    {16'h7FFF, 16'hFFFE},
    {16'hC3A5, 16'h5A3C}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pairValid = 1'b0;
  logic [15:0] leftIn = '0;
  logic [15:0] rightIn = '0;
  logic        pairReady, bitClk, wordSel, serData;

  int checks = 0;
  int failures = 0;
  int edgeErr = 0;
  int cyc = 0;
  logic prevSer = 1'b0, prevWs = 1'b0, prevBck = 1'b0;

  signext_dac_tx #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .pairValid(pairValid), .leftIn(leftIn), .rightIn(rightIn),
    .pairReady(pairReady), .bitClk(bitClk), .wordSel(wordSel), .serData(serData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pad(input logic [15:0] s);
    return {{8{s[15]}}, s};
  endfunction

  // R4 monitor: any change of data or word select outside a bit clock fall
  always @(negedge clk) begin
    if (rstN) begin
      if ((serData !== prevSer || wordSel !== prevWs) && !(prevBck && !bitClk))
        edgeErr++;
    end
    prevSer = serData;
    prevWs  = wordSel;
    prevBck = bitClk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  task automatic capture(output logic [47:0] bits, output logic [47:0] ws);
    logic prev;
    int n;
    bits = '0; ws = '0; n = 0;
    prev = bitClk;
    while (n < 48) begin
      @(negedge clk);
      if (!prev && bitClk) begin
        bits = {bits[46:0], serData};
        ws   = {ws[46:0], wordSel};
        n++;
      end
      prev = bitClk;
    end
  endtask

  // Offer a pair (or not) at the next frame boundary and check the frame sent
  task automatic frameCheck(input logic [15:0] l, input logic [15:0] r, input logic v,
                            input logic [15:0] expL, input logic [15:0] expR, input string tag);
    logic [47:0] bits, ws;
    leftIn = l; rightIn = r; pairValid = v;
    do @(negedge clk); while (!pairReady);
    @(negedge clk);
    // R6: strobe lasts one system clock
    check(pairReady == 1'b0, {tag, " R6 ready width"}, 64'(pairReady), 64'd0);
    pairValid = 1'b0;
    leftIn = ~l; rightIn = ~r;   // R7: changes after the strobe are ignored
    capture(bits, ws);
    check(bits[47:24] == pad(expL), {tag, " R1 left slot"}, 64'(bits[47:24]), 64'(pad(expL)));
    check(bits[23:0] == pad(expR), {tag, " R2 right slot"}, 64'(bits[23:0]), 64'(pad(expR)));
    check(ws == {24'hFFFFFF, 24'h0}, {tag, " R3 word select"}, 64'(ws), 64'({24'hFFFFFF, 24'h0}));
  endtask

  initial begin
    int hi, per;
    logic prev;
    repeat (3) @(negedge clk);
    // R8: reset state
    check({bitClk, wordSel, serData, pairReady} == 4'b0, "R8 reset outputs",
          64'({bitClk, wordSel, serData, pairReady}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(bitClk == 1'b0, "R5 bit clock low after reset", 64'(bitClk), 64'd0);

    // R8: first frame with nothing offered carries the cleared pair
    frameCheck(16'h5555, 16'hAAAA, 1'b0, 16'h0000, 16'h0000, "R8 first frame");

    for (int i = 0; i < NVEC; i++)
      frameCheck(VEC[i][31:16], VEC[i][15:0], 1'b1, VEC[i][31:16], VEC[i][15:0], "vector");

    // R7: no valid at the boundary, new values on the inputs -> previous pair again
    frameCheck(16'h0F0F, 16'hF0F0, 1'b0, VEC[NVEC-1][31:16], VEC[NVEC-1][15:0], "R7 repeat");
    frameCheck(16'h0F0F, 16'hF0F0, 1'b1, 16'h0F0F, 16'hF0F0, "R6 resume");

    // R5: period and high time of the bit clock
    prev = bitClk;
    do begin @(negedge clk); if (!prev && bitClk) break; prev = bitClk; end while (1);
    hi = 1; per = 1;
    while (bitClk) begin @(negedge clk); per++; if (bitClk) hi++; end
    while (!bitClk) begin @(negedge clk); per++; end
    per--;
    check(hi == DIV/2, "R5 high time", 64'(hi), 64'(DIV/2));
    check(per == DIV, "R5 period", 64'(per), 64'(DIV));

    check(edgeErr == 0, "R4 changes only on falling bit clock", 64'(edgeErr), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule